// File: doc/BRIEF.md
# Sector Read DMA Controller

This block fetches one fixed-size sector from a storage stream and copies it into system memory on its own. Software programs three registers through a small register port: the logical block number, the base memory address, and a command register. A write of the go bit to the command register starts the job. The controller turns the block number into a (surface, track, sector) triple using fixed geometry parameters. It presents that triple to the storage side as a request, takes the sector's bytes from a byte stream, packs them into 64-bit words and writes each word out through a valid/ready memory write port. When the last word has been accepted, the controller raises an interrupt line. The line stays high until software acknowledges it through the status register.

The controller is one state machine with five states. IDLE waits for a command. IDLE to REQ is taken on an accepted command with an in-range block. REQ holds the storage request and moves to FILL when the storage side accepts it. FILL gathers bytes and moves to PUSH when the word holds eight bytes. PUSH offers the word to memory. On acceptance it returns to FILL, or it moves to DONE after the final word. DONE raises the interrupt and returns to IDLE. A command whose block number is out of range never leaves IDLE: it sets the range error and the interrupt in the same edge.

Register map (2-bit index): 0 = command (bit 0 = go, reads as 0), 1 = logical block number, 2 = memory base address, 3 = status. Status read bits: 0 busy, 1 busy-command error, 2 range error, 3 interrupt pending. Writing status with bit 0 set is the acknowledge.

Top module: `blkdma_ctrl`

## Requirements
- R1: After reset the status reads 0, and irq, st_req_valid, st_data_ready and dma_valid are all low.
- R2: For block number n, the request carries st_sector = n mod SECTS_PER_TRACK, st_surface = (n / SECTS_PER_TRACK) mod SURFACES and st_track = n / (SECTS_PER_TRACK*SURFACES).
- R3: A command write (index 0, bit 0 set) while idle with an in-range block sets busy (status bit 0) from the next cycle and issues exactly one storage request.
- R4: Stream bytes are packed little-endian: the k-th byte of a word lands in dma_data bits [8k+7:8k]. Each word carries eight bytes.
- R5: One command produces SECT_BYTES/8 memory writes in order. Word i goes to the base address plus 8*i.
- R6: dma_valid stays high with dma_addr and dma_data unchanged until dma_ready. st_req_valid stays high with a stable triple until st_req_ready.
- R7: The interrupt rises two cycles after the final word is accepted, and busy clears in that same cycle.
- R8: The interrupt stays high until a status write with bit 0 set. That acknowledge clears the interrupt and both error bits.
- R9: A command write while busy is rejected. It sets status bit 1, and the running transfer completes unchanged.
- R10: A block number of NUM_BLOCKS or more sets status bit 2 and the interrupt one cycle after the command, with no storage request and no memory write.
- R11: Writes to the block number or base address registers while busy are ignored, which can be seen on readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Completion/error interrupt, held until acknowledged |
| st_req_valid | output | 1 | Storage request valid |
| st_req_ready | input | 1 | Storage request accepted |
| st_surface | output | 2 | Requested surface |
| st_track | output | 5 | Requested track |
| st_sector | output | 5 | Requested sector within track |
| st_data_valid | input | 1 | Storage byte valid |
| st_data_ready | output | 1 | Controller can take a byte |
| st_data | input | 8 | Storage byte |
| dma_valid | output | 1 | Memory write valid |
| dma_ready | input | 1 | Memory write accepted |
| dma_addr | output | 32 | Memory write byte address |
| dma_data | output | 64 | Memory write data |

## Verification
The bench aims at block numbers 0 and NUM_BLOCKS-1. A wrong divide or modulo in the geometry mapping shows up there as a bad triple or as data from the wrong sector. It also sends numbers just past and far past the limit, where a broken range check would start a transfer or stay silent. Random stalls on both the byte stream and the memory port catch a packer that drops or repeats a byte and a word that changes under backpressure. They also catch an off-by-one word count at the end of the sector. Commands and register writes issued in the middle of a transfer expose a controller that restarts, retargets its address or misses the error bit. Interrupt checks before and after the acknowledge catch a line that self-clears or does not clear at all.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

    localparam int REG_W = 32;

    // Register indexes
    localparam logic [1:0] RIDX_CMD  = 2'd0;
    localparam logic [1:0] RIDX_LBN  = 2'd1;
    localparam logic [1:0] RIDX_BASE = 2'd2;
    localparam logic [1:0] RIDX_STAT = 2'd3;

    // Bit positions
    localparam int CMD_GO_BIT   = 0;
    localparam int STAT_ACK_BIT = 0;
    localparam int STAT_BUSY    = 0;
    localparam int STAT_EBUSY   = 1;
    localparam int STAT_ERANGE  = 2;
    localparam int STAT_IRQ     = 3;

    typedef enum logic [2:0] {
        XS_IDLE,
        XS_REQ,
        XS_FILL,
        XS_PUSH,
        XS_DONE
    } xfer_state_t;

    function automatic int wbits(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/blkdma_geom.sv
module blkdma_geom #(
    parameter int SECTS = 32,
    parameter int SURFS = 4,
    parameter int SEC_W = 5,
    parameter int SRF_W = 2,
    parameter int TRK_W = 5
) (
    input  logic [blkdma_pkg::REG_W-1:0] lbn_i,
    output logic [SEC_W-1:0]             sector_o,
    output logic [SRF_W-1:0]             surface_o,
    output logic [TRK_W-1:0]             track_o
);
    localparam int CYL = SECTS * SURFS;

    logic [blkdma_pkg::REG_W-1:0] per_trk;

    always_comb begin
        per_trk   = lbn_i / blkdma_pkg::REG_W'(SECTS);
        sector_o  = SEC_W'(lbn_i % blkdma_pkg::REG_W'(SECTS));
        surface_o = SRF_W'(per_trk % blkdma_pkg::REG_W'(SURFS));
        track_o   = TRK_W'(lbn_i / blkdma_pkg::REG_W'(CYL));
    end
endmodule

// File: rtl/blkdma_pack.sv
module blkdma_pack #(
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [7:0]        byte_i,
    input  logic              clear_i,
    output logic [WORD_W-1:0] word_o,
    output logic              full_o
);
    localparam int LANES = WORD_W / 8;
    localparam int CNT_W = blkdma_pkg::wbits(LANES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear_i)
            cnt_q <= '0;
        else if (take_i)
            cnt_q <= cnt_q + 1'b1;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_o[g*8 +: 8] <= 8'h00;
            else if (take_i && !clear_i && cnt_q == CNT_W'(g))
                word_o[g*8 +: 8] <= byte_i;
        end
    end

    assign full_o = (cnt_q == CNT_W'(LANES));

    // R4: the lane counter never runs past one word
    a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(LANES));
    // R4: no byte is taken into a full word
    a_r4_no_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !take_i);
endmodule

// File: rtl/blkdma_regs.sv
module blkdma_regs (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic [1:0]                    addr_i,
    input  logic [blkdma_pkg::REG_W-1:0]  wdata_i,
    input  logic                          busy_i,
    input  logic                          done_i,
    input  logic                          range_rej_i,
    output logic                          start_o,
    output logic [blkdma_pkg::REG_W-1:0]  lbn_o,
    output logic [blkdma_pkg::REG_W-1:0]  base_o,
    output logic                          irq_o,
    output logic [blkdma_pkg::REG_W-1:0]  rdata_o
);
    import blkdma_pkg::*;

    logic cmd_go, ack, err_busy_q, err_range_q;

    assign cmd_go  = we_i && addr_i == RIDX_CMD  && wdata_i[CMD_GO_BIT];
    assign ack     = we_i && addr_i == RIDX_STAT && wdata_i[STAT_ACK_BIT];
    assign start_o = cmd_go && !busy_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lbn_o  <= '0;
            base_o <= '0;
        end else if (we_i && !busy_i) begin
            if (addr_i == RIDX_LBN)  lbn_o  <= wdata_i;
            if (addr_i == RIDX_BASE) base_o <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_busy_q  <= 1'b0;
            err_range_q <= 1'b0;
            irq_o       <= 1'b0;
        end else begin
            if (cmd_go && busy_i)         err_busy_q  <= 1'b1;
            else if (ack)                 err_busy_q  <= 1'b0;
            if (range_rej_i)              err_range_q <= 1'b1;
            else if (ack)                 err_range_q <= 1'b0;
            if (done_i || range_rej_i)    irq_o       <= 1'b1;
            else if (ack)                 irq_o       <= 1'b0;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            RIDX_CMD:  rdata_o = '0;
            RIDX_LBN:  rdata_o = lbn_o;
            RIDX_BASE: rdata_o = base_o;
            RIDX_STAT: begin
                rdata_o[STAT_BUSY]   = busy_i;
                rdata_o[STAT_EBUSY]  = err_busy_q;
                rdata_o[STAT_ERANGE] = err_range_q;
                rdata_o[STAT_IRQ]    = irq_o;
            end
            default:   rdata_o = '0;
        endcase
    end

    // R8: a pending interrupt survives until acknowledged
    a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !ack |=> irq_o);
    // R9: a command during a transfer raises the busy error
    a_r9_busy_cmd_flag: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go && busy_i |=> err_busy_q);
    // R11: programming registers are frozen while busy
    a_r11_regs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(lbn_o) && $stable(base_o));
endmodule

// File: rtl/blkdma_ctrl.sv
module blkdma_ctrl #(
    parameter int SECT_BYTES      = 512,
    parameter int SECTS_PER_TRACK = 32,
    parameter int SURFACES        = 4,
    parameter int NUM_BLOCKS      = 4096,
    parameter int WORD_W          = 64,
    localparam int SEC_W  = blkdma_pkg::wbits(SECTS_PER_TRACK),
    localparam int SRF_W  = blkdma_pkg::wbits(SURFACES),
    localparam int TRK_W  = blkdma_pkg::wbits(NUM_BLOCKS / (SECTS_PER_TRACK * SURFACES)),
    localparam int AW     = blkdma_pkg::REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [AW-1:0]     reg_wdata,
    output logic [AW-1:0]     reg_rdata,
    output logic              irq,
    output logic              st_req_valid,
    input  logic              st_req_ready,
    output logic [SRF_W-1:0]  st_surface,
    output logic [TRK_W-1:0]  st_track,
    output logic [SEC_W-1:0]  st_sector,
    input  logic              st_data_valid,
    output logic              st_data_ready,
    input  logic [7:0]        st_data,
    output logic              dma_valid,
    input  logic              dma_ready,
    output logic [AW-1:0]     dma_addr,
    output logic [WORD_W-1:0] dma_data
);
    import blkdma_pkg::*;

    localparam int WBYTES = WORD_W / 8;
    localparam int WORDS  = SECT_BYTES / WBYTES;
    localparam int IDX_W  = wbits(WORDS);
    localparam int SH     = $clog2(WBYTES);

    xfer_state_t state_q, state_d;

    logic          start, range_bad, range_rej, busy, done;
    logic [AW-1:0] lbn, base;
    logic          pk_full, take, push_fire, last_word;
    logic [IDX_W-1:0] word_idx_q;

    blkdma_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (reg_we),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .busy_i     (busy),
        .done_i     (done),
        .range_rej_i(range_rej),
        .start_o    (start),
        .lbn_o      (lbn),
        .base_o     (base),
        .irq_o      (irq),
        .rdata_o    (reg_rdata)
    );

    blkdma_geom #(
        .SECTS(SECTS_PER_TRACK), .SURFS(SURFACES),
        .SEC_W(SEC_W), .SRF_W(SRF_W), .TRK_W(TRK_W)
    ) u_geom (
        .lbn_i    (lbn),
        .sector_o (st_sector),
        .surface_o(st_surface),
        .track_o  (st_track)
    );

    blkdma_pack #(.WORD_W(WORD_W)) u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take),
        .byte_i (st_data),
        .clear_i(push_fire),
        .word_o (dma_data),
        .full_o (pk_full)
    );

    assign range_bad = (lbn >= AW'(NUM_BLOCKS));
    assign range_rej = start && range_bad;
    assign take      = st_data_valid && st_data_ready;
    assign push_fire = dma_valid && dma_ready;
    assign last_word = (word_idx_q == IDX_W'(WORDS - 1));
    assign dma_addr  = base + ({{(AW-IDX_W){1'b0}}, word_idx_q} << SH);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE: if (start && !range_bad) state_d = XS_REQ;
            XS_REQ:  if (st_req_ready)        state_d = XS_FILL;
            XS_FILL: if (pk_full)             state_d = XS_PUSH;
            XS_PUSH: if (dma_ready)           state_d = last_word ? XS_DONE : XS_FILL;
            XS_DONE:                          state_d = XS_IDLE;
            default:                          state_d = XS_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        st_req_valid  = 1'b0;
        st_data_ready = 1'b0;
        dma_valid     = 1'b0;
        done          = 1'b0;
        busy          = 1'b1;
        unique case (state_q)
            XS_IDLE: busy          = 1'b0;
            XS_REQ:  st_req_valid  = 1'b1;
            XS_FILL: st_data_ready = !pk_full;
            XS_PUSH: dma_valid     = 1'b1;
            XS_DONE: done          = 1'b1;
            default: busy          = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         word_idx_q <= '0;
        else if (start)     word_idx_q <= '0;
        else if (push_fire) word_idx_q <= word_idx_q + 1'b1;
    end

    // R6: memory write held under backpressure
    a_r6_dma_hold: assert property (@(posedge clk) disable iff (!rst_n)
        dma_valid && !dma_ready |=> dma_valid && $stable(dma_addr) && $stable(dma_data));
    // R6: storage request held under backpressure
    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        st_req_valid && !st_req_ready |=> st_req_valid && $stable(st_sector)
            && $stable(st_surface) && $stable(st_track));
    // R7: completion raises the interrupt as busy drops
    a_r7_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == XS_DONE |=> irq && state_q == XS_IDLE);
    // R10: out-of-range command interrupts without leaving idle
    a_r10_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start && range_bad |=> irq && state_q == XS_IDLE);
    // R3: an accepted command leads to a storage request
    a_r3_start_req: assert property (@(posedge clk) disable iff (!rst_n)
        start && !range_bad |=> st_req_valid);
endmodule

// File: tb/sim_blkdma_ctrl.sv
module sim_blkdma_ctrl;
    localparam int SB = 512, SPT = 32, SRF = 4, NB = 4096, WW = 64;
    localparam int NWORDS = SB / 8;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        irq, st_req_valid, st_req_ready = 1'b0;
    logic [1:0]  st_surface;
    logic [4:0]  st_track, st_sector;
    logic        st_data_valid = 1'b0, st_data_ready;
    logic [7:0]  st_data = '0;
    logic        dma_valid, dma_ready = 1'b0;
    logic [31:0] dma_addr;
    logic [63:0] dma_data;

    always #10 clk = ~clk;

    blkdma_ctrl #(.SECT_BYTES(SB), .SECTS_PER_TRACK(SPT), .SURFACES(SRF),
                  .NUM_BLOCKS(NB), .WORD_W(WW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .st_req_valid(st_req_valid), .st_req_ready(st_req_ready),
        .st_surface(st_surface), .st_track(st_track), .st_sector(st_sector),
        .st_data_valid(st_data_valid), .st_data_ready(st_data_ready), .st_data(st_data),
        .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_addr(dma_addr), .dma_data(dma_data));

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_fn(input int srf, input int trk, input int sec, input int k);
        return 8'((k * 37) + sec * 11 + trk * 97 + srf * 53);
    endfunction

    int exp_lbn;
    logic [31:0] exp_base;
    int m_words, m_reqs;

    function automatic logic [63:0] exp_word(input int idx);
        logic [63:0] w;
        int sec = exp_lbn % SPT, srf = (exp_lbn / SPT) % SRF, trk = exp_lbn / (SPT * SRF);
        for (int b = 0; b < 8; b++) w[b*8 +: 8] = byte_fn(srf, trk, sec, idx * 8 + b);
        return w;
    endfunction

    // Storage and memory model
    bit req_fire = 0, byte_fire = 0, word_fire = 0, stream_on = 0;
    int byte_k = 0, c_srf, c_trk, c_sec;
    logic [31:0] cap_addr;
    logic [63:0] cap_data;

    always @(negedge clk) begin
        if (rst_n) begin
            if (req_fire) begin
                m_reqs++;
                chk("R2 sector", 64'(c_sec), 64'(exp_lbn % SPT));
                chk("R2 surface", 64'(c_srf), 64'((exp_lbn / SPT) % SRF));
                chk("R2 track", 64'(c_trk), 64'(exp_lbn / (SPT * SRF)));
                stream_on = 1; byte_k = 0;
            end
            if (byte_fire) begin
                byte_k++;
                if (byte_k == SB) stream_on = 0;
            end
            if (word_fire) begin
                chk("R5 address", 64'(cap_addr), 64'(exp_base + 32'(m_words * 8)));
                chk("R4 data", cap_data, exp_word(m_words));
                m_words++;
            end
            st_req_ready = ($urandom % 3) != 0;
            dma_ready    = ($urandom % 4) != 0;
            if (!(st_data_valid && !byte_fire)) begin
                if (stream_on && ($urandom % 4) != 0) begin
                    st_data_valid = 1'b1;
                    st_data = byte_fn(c_srf, c_trk, c_sec, byte_k);
                end else st_data_valid = 1'b0;
            end
            req_fire  = st_req_valid && st_req_ready;
            byte_fire = st_data_valid && st_data_ready;
            word_fire = dma_valid && dma_ready;
            if (req_fire) begin
                c_srf = int'(st_surface); c_trk = int'(st_track); c_sec = int'(st_sector);
            end
            cap_addr = dma_addr; cap_data = dma_data;
        end
    end

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic wait_irq(output bit tmo);
        tmo = 1;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk); #1;
            if (irq) begin tmo = 0; break; end
        end
    endtask

    task automatic run_xfer(input int lbn, input logic [31:0] base, input bit inject);
        logic [31:0] d;
        bit tmo;
        exp_lbn = lbn; exp_base = base; m_words = 0; m_reqs = 0;
        reg_write(2'd1, 32'(lbn));
        reg_write(2'd2, base);
        reg_write(2'd0, 32'h1);
        reg_read(2'd3, d);
        chk("R3 busy after command", 64'(d[0]), 64'd1);
        if (inject) begin
            repeat (20) @(negedge clk);
            reg_write(2'd0, 32'h1);
            reg_write(2'd1, 32'(lbn) ^ 32'h5);
            reg_write(2'd2, base + 32'h40);
            reg_read(2'd1, d); chk("R11 block number frozen", 64'(d), 64'(lbn));
            reg_read(2'd2, d); chk("R11 base frozen", 64'(d), 64'(base));
            reg_read(2'd3, d); chk("R9 busy error flag", 64'(d[1:0]), 64'd3);
        end
        wait_irq(tmo);
        chk("R7 interrupt seen", 64'(tmo), 64'd0);
        chk("R5 word count", 64'(m_words), 64'(NWORDS));
        chk("R3 single request", 64'(m_reqs), 64'd1);
        reg_read(2'd3, d);
        chk("R7 status at end", 64'(d[3:0]), inject ? 64'hA : 64'h8);
        repeat (5) @(negedge clk);
        chk("R8 interrupt held", 64'(irq), 64'd1);
        reg_write(2'd3, 32'h1);
        chk("R8 interrupt cleared", 64'(irq), 64'd0);
        reg_read(2'd3, d);
        chk("R8 status cleared", 64'(d), 64'd0);
    endtask

    task automatic run_reject(input logic [31:0] lbn);
        logic [31:0] d;
        m_words = 0; m_reqs = 0;
        reg_write(2'd1, lbn);
        reg_write(2'd0, 32'h1);
        chk("R10 interrupt at once", 64'(irq), 64'd1);
        repeat (30) @(negedge clk);
        reg_read(2'd3, d);
        chk("R10 status range error", 64'(d[3:0]), 64'hC);
        chk("R10 no memory write", 64'(m_words), 64'd0);
        chk("R10 no storage request", 64'(m_reqs), 64'd0);
        reg_write(2'd3, 32'h1);
        reg_read(2'd3, d);
        chk("R8 range error cleared", 64'(d), 64'd0);
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20517));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 irq low", 64'(irq), 64'd0);
        chk("R1 no request", 64'(st_req_valid), 64'd0);
        chk("R1 no byte ready", 64'(st_data_ready), 64'd0);
        chk("R1 no write", 64'(dma_valid), 64'd0);
        reg_read(2'd3, d);
        chk("R1 status zero", 64'(d), 64'd0);
        run_xfer(0, 32'h1000_0000, 0);
        run_xfer(NB - 1, 32'h0000_8000, 0);
        run_xfer(165, 32'h0002_0004, 1);
        run_reject(32'(NB));
        run_reject(32'hFFFF_FFFF);
        for (int i = 0; i < 6; i++)
            run_xfer(int'($urandom % NB), $urandom, (i % 3) == 2);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule